// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block pulls 32-bit command words out of a circular buffer that software keeps in system memory. The buffer sits at a 64-bit base address on a 128-byte boundary and holds 256 one-dword slots. Software fills slots, then moves a producer index forward. The engine keeps a consumer index of its own and steps it one slot at a time. After each step it reads the slot the index now names. It stops when the two indices match. Each word it reads goes out on a valid/ready command stream.

Software reaches the block through a small register port. Writes take effect on a clock edge and reads are combinational. A run bit starts and stops the engine. Software may move the producer index at any time, including while the engine runs. The base address is locked while the engine runs or still has a read in flight. Memory is reached through a read request channel and a response channel. The engine keeps at most one read outstanding and starts no read while its output slot is still full.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After reset, every register reads zero, `mem_req_valid` is low and `cmd_valid` is low.
- R2: The low base register is at offset 0x40 and the high base register at offset 0x44. In the low register, bits 6:0 always read zero and writes to them are dropped. All other bits of both registers hold what was written.
- R3: The producer index is in bits 7:0 of the register at offset 0x48. Bits 31:8 of that register always read zero.
- R4: The address for slot n is the 64-bit base plus 4·n, with the carry running into the upper dword. The engine reads slots from one past its consumer index up to and including the producer index, in order, once each, and places each word on `cmd_data`.
- R5: The consumer index wraps from 255 to 0, so fetching continues across the end of the ring.
- R6: When the producer index is moved forward while fetching is under way, the engine carries on up to the new value.
- R7: Writes to either base register are dropped while the run bit is set or a read is in flight.
- R8: The control register is at offset 0x4C. Bit 0 is the run bit. Bit 2 reads 1 while a read is in flight. After run is cleared, at most one more read is accepted by memory, bit 2 returns to 0, and no further read requests appear.
- R9: Bits 15:8 of the control register read the consumer index. Writing 1 to bit 1 resets the consumer index to zero, but only if the engine was stopped and had no read in flight before that write. Bit 1 reads as zero.
- R10: At most one memory read is outstanding. A request holds its address until memory accepts it. No read is started while `cmd_valid` is high.
- R11: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the dword to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned dword |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Consumer takes the command word |
| cmd_data | output | 32 | Command word |

## Verification
Two situations are hard to reach from the ports. The first is a producer index that changes while a read is still in flight. The second is a run bit that drops while a request is either waiting for acceptance or waiting for data. The bench gets there by stretching memory latency to several cycles and throttling request acceptance. It then writes the new producer index, or clears the run bit, partway through a long fetch. The stream it collects is compared against slot addresses that the bench computes itself. Each returned word encodes its own address, so any skipped, repeated or misplaced slot shows up as a mismatch. Wrap-around is reached by first draining the ring up to slot 255 and then pointing the producer index at a low slot.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_BASE_LO = 8'h40;
  localparam logic [REG_AW-1:0] OFS_BASE_HI = 8'h44;
  localparam logic [REG_AW-1:0] OFS_WPTR    = 8'h48;
  localparam logic [REG_AW-1:0] OFS_CTRL    = 8'h4C;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_CLR  = 1;
  localparam int CTRL_BUSY = 2;
  localparam int CTRL_RP   = 8;

  localparam int SLOT_SHIFT = 2;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fetch_state_e;

  // Byte address of one ring slot.
  function automatic logic [63:0] slot_addr(input logic [63:0] base,
                                            input logic [15:0] idx);
    return base + (64'(idx) << SLOT_SHIFT);
  endfunction

  // Low base word with the alignment bits forced to zero.
  function automatic logic [31:0] align_low(input logic [31:0] raw,
                                            input int          bits);
    logic [31:0] keep;
    keep = ~((32'd1 << bits) - 32'd1);
    return raw & keep;
  endfunction

endpackage

// File: rtl/ring_regs.sv
module ring_regs
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W      = 8,
  parameter int ALIGN_BITS = 7,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              engine_busy,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [63:0]       ring_base,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic              run,
  output logic              rp_clear
);

  logic [31:0]      base_lo_q;
  logic [31:0]      base_hi_q;
  logic [PTR_W-1:0] wp_q;
  logic             run_q;
  logic             base_lock;
  logic             hit_lo, hit_hi, hit_wp, hit_ctrl;

  assign base_lock = run_q | engine_busy;
  assign hit_lo    = reg_we && (reg_addr == OFS_BASE_LO);
  assign hit_hi    = reg_we && (reg_addr == OFS_BASE_HI);
  assign hit_wp    = reg_we && (reg_addr == OFS_WPTR);
  assign hit_ctrl  = reg_we && (reg_addr == OFS_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
    end else if (!base_lock) begin
      if (hit_lo) base_lo_q <= align_low(reg_wdata[31:0], ALIGN_BITS);
      if (hit_hi) base_hi_q <= reg_wdata[31:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      run_q <= 1'b0;
    end else begin
      if (hit_wp)   wp_q  <= reg_wdata[PTR_W-1:0];
      if (hit_ctrl) run_q <= reg_wdata[CTRL_RUN];
    end
  end

  // Clearing is honoured only when stopped and drained before this write.
  assign rp_clear  = hit_ctrl && reg_wdata[CTRL_CLR] && !run_q && !engine_busy;

  assign ring_base = {base_hi_q, base_lo_q};
  assign wr_ptr    = wp_q;
  assign run       = run_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_BASE_LO: reg_rdata[31:0] = base_lo_q;
      OFS_BASE_HI: reg_rdata[31:0] = base_hi_q;
      OFS_WPTR:    reg_rdata[PTR_W-1:0] = wp_q;
      OFS_CTRL: begin
        reg_rdata[CTRL_RUN]             = run_q;
        reg_rdata[CTRL_BUSY]            = engine_busy;
        reg_rdata[CTRL_RP +: PTR_W]     = rd_ptr;
      end
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ring_fetch_ctrl.sv
module ring_fetch_ctrl
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [63:0]      ring_base,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic             rp_clear,
  input  logic             slot_empty,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  output logic             mem_req_valid,
  output logic [63:0]      mem_req_addr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             busy,
  output logic             launch,
  output logic             rsp_take
);

  fetch_state_e     state_q;
  logic [PTR_W-1:0] rp_q;
  logic [PTR_W-1:0] rp_nxt;
  logic [63:0]      addr_q;

  assign rp_nxt   = rp_q + 1'b1;
  assign launch   = (state_q == FS_IDLE) && run && (rp_q != wr_ptr) && slot_empty;
  assign rsp_take = (state_q == FS_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      rp_q    <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        FS_IDLE: begin
          if (rp_clear) begin
            rp_q <= '0;
          end else if (launch) begin
            rp_q    <= rp_nxt;
            addr_q  <= slot_addr(ring_base, 16'(rp_nxt));
            state_q <= FS_REQ;
          end
        end
        FS_REQ:  if (mem_req_ready) state_q <= FS_WAIT;
        FS_WAIT: if (mem_rsp_valid) state_q <= FS_IDLE;
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state_q == FS_REQ);
  assign mem_req_addr  = addr_q;
  assign rd_ptr        = rp_q;
  assign busy          = (state_q != FS_IDLE);

endmodule

// File: rtl/cmd_out_slot.sv
module cmd_out_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DATA_W-1:0] cmd_data,
  output logic              empty
);

  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (load) begin
      vld_q <= 1'b1;
      dat_q <= load_data;
    end else if (cmd_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign cmd_valid = vld_q;
  assign cmd_data  = dat_q;
  assign empty     = !vld_q;

endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W      = 8,
  parameter int ALIGN_BITS = 7,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DATA_W-1:0] cmd_data
);

  logic [63:0]      ring_base;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             run;
  logic             rp_clear;
  logic             busy;
  logic             launch;
  logic             rsp_take;
  logic             slot_empty;

  ring_regs #(
    .PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .engine_busy(busy), .rd_ptr(rd_ptr),
    .ring_base(ring_base), .wr_ptr(wr_ptr), .run(run), .rp_clear(rp_clear)
  );

  ring_fetch_ctrl #(
    .PTR_W(PTR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .run(run), .ring_base(ring_base), .wr_ptr(wr_ptr), .rp_clear(rp_clear),
    .slot_empty(slot_empty),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .rd_ptr(rd_ptr), .busy(busy), .launch(launch), .rsp_take(rsp_take)
  );

  cmd_out_slot #(
    .DATA_W(DATA_W)
  ) u_slot (
    .clk(clk), .rst_n(rst_n),
    .load(rsp_take), .load_data(mem_rsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .empty(slot_empty)
  );

endmodule

// File: rtl/cmd_ring_fetch_chk.sv
module cmd_ring_fetch_chk
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [63:0]       mem_req_addr,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [DATA_W-1:0] cmd_data,
  input logic              launch,
  input logic              rsp_take,
  input logic              run,
  input logic              rp_clear,
  input logic [PTR_W-1:0]  rd_ptr,
  input logic [PTR_W-1:0]  wr_ptr
);

  logic [1:0] inflight;
  logic       req_fire;

  assign req_fire = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     inflight <= 2'd0;
    else if (req_fire && !rsp_take) inflight <= inflight + 2'd1;
    else if (rsp_take && !req_fire) inflight <= inflight - 2'd1;
  end

  AST_BASE_LO_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_BASE_LO) |-> (reg_rdata[6:0] == 7'd0)); // R2

  AST_WPTR_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_WPTR) |-> (reg_rdata[DATA_W-1:PTR_W] == '0)); // R3

  AST_LAUNCH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (rd_ptr != wr_ptr)); // R4

  AST_RP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (rd_ptr == PTR_W'($past(rd_ptr) + 1'b1))); // R5

  AST_NO_LAUNCH_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> run); // R8

  AST_RP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch && !rp_clear) |=> $stable(rd_ptr)); // R9

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> (inflight == 2'd0)); // R10

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10

  AST_NO_LAUNCH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !cmd_valid); // R10

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data))); // R11

endmodule

bind cmd_ring_fetch cmd_ring_fetch_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .launch(launch), .rsp_take(rsp_take), .run(run),
  .rp_clear(rp_clear), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
);

// File: tb/cmd_ring_fetch_bench.sv
module cmd_ring_fetch_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_LO = 8'h40, A_HI = 8'h44, A_WP = 8'h48, A_CT = 8'h4C;

  typedef struct packed {
    logic [63:0] base;
    logic [7:0]  wp;
    logic [3:0]  lat;
    logic        slow_mem;
    logic        slow_out;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{64'h0000_0001_2345_6780, 8'd5,   4'd1, 1'b0, 1'b0},
    '{64'h0000_0002_FFFF_FF80, 8'd40,  4'd3, 1'b1, 1'b0},
    '{64'h8000_0000_0000_0000, 8'd0,   4'd0, 1'b0, 1'b0},
    '{64'h0000_00AB_CDEF_0100, 8'd255, 4'd0, 1'b0, 1'b1}
  };

  logic        clk, rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [63:0] mem_req_addr;
  logic [31:0] mem_rsp_data;
  logic        cmd_valid, cmd_ready;
  logic [31:0] cmd_data;

  cmd_ring_fetch u_cmd_ring_fetch (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data)
  );

  int          n_chk = 0, n_fail = 0;
  int          cyc = 0;
  int          mem_lat = 0;
  bit          slow_mem = 0, slow_out = 0;
  int          pend_cnt = -1;
  logic [63:0] pend_addr;
  int          req_count = 0;
  logic [31:0] got [0:1023];
  int          ngot = 0;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // Each memory dword encodes its own address.
  function automatic logic [31:0] mem_word(input logic [63:0] a);
    return a[31:0] ^ {a[47:32], a[63:48]} ^ 32'h3C5A_0000;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // Memory model: one response per accepted request after mem_lat cycles.
  always @(negedge clk) begin
    if (rst_n) begin
      mem_rsp_valid = 1'b0;
      if (pend_cnt > 0) pend_cnt--;
      else if (pend_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(pend_addr);
        pend_cnt      = -1;
      end
      mem_req_ready = slow_mem ? (cyc % 3 == 0) : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        if (pend_cnt != -1 || mem_rsp_valid) begin
          n_chk++;
          n_fail++;
          $display("FAIL R10 second read accepted: actual 2 expected 1");
        end
        pend_addr = mem_req_addr;
        pend_cnt  = mem_lat;
        req_count++;
      end
    end
  end

  // Command consumer with optional back-pressure.
  always @(negedge clk) begin
    cmd_ready = slow_out ? (cyc % 4 != 1) : 1'b1;
    if (rst_n && cmd_valid && cmd_ready) begin
      got[ngot % 1024] = cmd_data;
      ngot++;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int t;
    t = 0;
    v = 32'hFFFF_FFFF;
    while (t < 3000 && (v[2] || cmd_valid || pend_cnt != -1)) begin
      rd(A_CT, v);
      t++;
    end
    check(t < 3000, req, "engine drains", 64'(v[2]), 64'd0);
  endtask

  task automatic collect(input int start, input int n);
    int t;
    t = 0;
    while (ngot < start + n && t < 8000) begin
      @(negedge clk);
      t++;
    end
    repeat (30) @(negedge clk);
  endtask

  task automatic expect_run(input string req, input int start, input logic [63:0] base,
                            input int first, input int n);
    check(ngot - start == n, req, "command count", 64'(ngot - start), 64'(n));
    for (int k = 0; k < n && start + k < ngot; k++) begin
      logic [63:0] a;
      a = base + 64'(((first + k) % 256) * 4);
      check(got[(start + k) % 1024] == mem_word(a), req, "command word",
            64'(got[(start + k) % 1024]), 64'(mem_word(a)));
    end
  endtask

  initial begin
    logic [31:0] v;
    logic [63:0] base3;
    int          s, rq;
    reg_we = 0; reg_addr = '0; reg_wdata = '0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0; cmd_ready = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(A_LO, v); check(v == 0, "R1", "base low after reset", 64'(v), 0);
    rd(A_HI, v); check(v == 0, "R1", "base high after reset", 64'(v), 0);
    rd(A_WP, v); check(v == 0, "R1", "write index after reset", 64'(v), 0);
    rd(A_CT, v); check(v == 0, "R1", "control after reset", 64'(v), 0);
    check(!mem_req_valid && !cmd_valid, "R1", "outputs idle", 64'({mem_req_valid, cmd_valid}), 0);

    // R3: reserved upper bits of the write index register
    wr(A_WP, 32'hFFFF_FF12);
    rd(A_WP, v); check(v == 32'h12, "R3", "write index readback", 64'(v), 64'h12);

    // Vector table: R2, R4, R9, R10, R11
    foreach (VECS[i]) begin
      wr(A_CT, 32'h0);
      wait_idle("R8");
      mem_lat  = int'(VECS[i].lat);
      slow_mem = VECS[i].slow_mem;
      slow_out = VECS[i].slow_out;
      wr(A_LO, VECS[i].base[31:0] | 32'h55);
      wr(A_HI, VECS[i].base[63:32]);
      wr(A_CT, 32'h2);
      rd(A_LO, v); check(v == VECS[i].base[31:0], "R2", "aligned base low", 64'(v), 64'(VECS[i].base[31:0]));
      rd(A_HI, v); check(v == VECS[i].base[63:32], "R2", "base high", 64'(v), 64'(VECS[i].base[63:32]));
      rd(A_CT, v); check(v[15:8] == 0, "R9", "index cleared while stopped", 64'(v[15:8]), 0);
      wr(A_WP, 32'(VECS[i].wp));
      s = ngot;
      wr(A_CT, 32'h1);
      collect(s, int'(VECS[i].wp));
      expect_run("R4", s, VECS[i].base, 1, int'(VECS[i].wp));
      rd(A_CT, v); check(v[15:8] == VECS[i].wp, "R9", "read index after drain", 64'(v[15:8]), 64'(VECS[i].wp));
    end
    base3 = VECS[3].base;
    slow_out = 0;

    // R7: base locked while running (engine idle, index 255)
    wr(A_LO, 32'h1111_1180);
    rd(A_LO, v); check(v == base3[31:0], "R7", "base low locked", 64'(v), 64'(base3[31:0]));
    wr(A_HI, 32'h2222_2222);
    rd(A_HI, v); check(v == base3[63:32], "R7", "base high locked", 64'(v), 64'(base3[63:32]));

    // R5: wrap from 255 through 0 up to 3
    s = ngot;
    wr(A_WP, 32'd3);
    collect(s, 4);
    expect_run("R5", s, base3, 0, 4);

    // R9: clear refused while running, refused on the stopping write, then taken
    wr(A_CT, 32'h3);
    rd(A_CT, v); check(v[15:8] == 8'd3, "R9", "clear ignored while running", 64'(v[15:8]), 3);
    wr(A_CT, 32'h2);
    rd(A_CT, v); check(v[15:8] == 8'd3 && v[0] == 0, "R9", "clear ignored on stop write", 64'(v[15:0]), 64'h0300);
    wr(A_CT, 32'h2);
    rd(A_CT, v); check(v[15:8] == 8'd0 && v[1] == 0, "R9", "clear while stopped", 64'(v[15:0]), 0);

    // R6: producer index moved while a slow fetch is under way
    mem_lat = 6; slow_mem = 1;
    wr(A_WP, 32'd4);
    s = ngot;
    wr(A_CT, 32'h1);
    repeat (8) @(negedge clk);
    wr(A_WP, 32'd10);
    collect(s, 10);
    expect_run("R6", s, base3, 1, 10);

    // R8: stop mid-stream with a slow memory
    wr(A_CT, 32'h0);
    wait_idle("R8");
    wr(A_CT, 32'h2);
    mem_lat = 8;
    wr(A_WP, 32'd200);
    s = ngot;
    wr(A_CT, 32'h1);
    while (ngot < s + 5) @(negedge clk);
    wr(A_CT, 32'h0);
    rq = req_count;
    wait_idle("R8");
    check(req_count - rq <= 1, "R8", "reads accepted after stop", 64'(req_count - rq), 1);
    rq = req_count;
    repeat (60) @(negedge clk);
    check(req_count == rq && !mem_req_valid, "R8", "no reads while stopped", 64'(req_count - rq), 0);
    rd(A_CT, v);
    check(v[2] == 0 && v[0] == 0, "R8", "busy and run low", 64'(v[2:0]), 0);
    check(int'(v[15:8]) == ngot - s, "R8", "index matches delivered", 64'(v[15:8]), 64'(ngot - s));
    expect_run("R8", s, base3, 1, int'(v[15:8]));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule